// File: doc/BRIEF.md
# Streaming 7x7 Neighbourhood Window Generator

The block takes a raster-ordered pixel stream, at most one pixel per clock, qualified by a valid strobe. It stores the previous six image lines in line delays, stacks them with the current line, and passes each of the seven rows through a short shift chain. The result is a full 7x7 neighbourhood presented in parallel on one wide bus. A downstream filter stage consumes this neighbourhood and computes one output pixel per window.

Frames follow each other with no gap. The block keeps two raster counters. One follows the incoming pixel. The other follows the centre of the window now on the output, which lags the input by three lines and three pixels. Every pixel position of every frame is therefore emitted exactly once as a centre, so the output image has the same dimensions as the input. Centres closer than three pixels to any edge of the frame are marked as border, and their window is forced to zero. Centres further in are marked window-valid. An end-of-frame pulse follows the last pixel of each input frame. Pixel words are 13 bits wide, which leaves room for pixels converted to a wider number format.

Top module: `win7_gen`

## Requirements
- R1: While rst_ni is low, out_stb_o, win_valid_o, border_o and eof_o are 0, and win_o, ctr_row_o and ctr_col_o are all zero.
- R2: Input is accepted only in cycles with pix_valid_i high. A cycle with pix_valid_i low causes no out_stb_o and no eof_o in the following cycle, and it does not advance any stored state.
- R3: out_stb_o pulses in the cycle right after an accepted pixel, provided that at least 3*IMG_W+3 pixels had been accepted since reset before that pixel. The first output is centre (row 0, col 0), produced by the input pixel at (row 3, col 3).
- R4: ctr_row_o and ctr_col_o give the centre of the presented window. Successive strobes step through the frame in raster order, with the column wrapping at IMG_W and the row wrapping at IMG_H, over consecutive frames.
- R5: For an interior centre (cy, cx), the field win_o[(r*7+c)*13 +: 13] holds the input pixel at (cy-3+r, cx-3+c) of the same frame. Here r=0 is the top row and c=0 is the left column.
- R6: win_valid_o is high exactly on strobes whose centre satisfies 3 <= row <= IMG_H-4 and 3 <= col <= IMG_W-4. The first such centre is (3, 3).
- R7: border_o is high exactly on strobes whose centre is not interior, and win_o is all zero in those cycles.
- R8: eof_o is a single-cycle pulse in the cycle after the pixel at (IMG_H-1, IMG_W-1) is accepted. In that same cycle the strobe presents the last interior centre (IMG_H-4, IMG_W-4) with win_valid_o high.
- R9: win_valid_o and border_o are never high together, and neither is high without out_stb_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Input pixel qualifier |
| pix_i | input | DW | Input pixel word |
| win_o | output | WIN*WIN*DW | Neighbourhood, field (r*WIN+c), row-major from top left |
| out_stb_o | output | 1 | A window is presented this cycle |
| win_valid_o | output | 1 | Presented centre is interior |
| border_o | output | 1 | Presented centre is on the border; window zeroed |
| ctr_row_o | output | RW | Row of presented centre |
| ctr_col_o | output | CW | Column of presented centre |
| eof_o | output | 1 | Last pixel of an input frame was accepted |

## Verification
The end-of-frame pulse and the strobe of the last interior window land in the same cycle, because both come from the final pixel of a frame. The bench streams four back-to-back frames of a reduced 10x8 image with irregular stall cycles, so that this coincidence is reached with and without a stall just before the final pixel. In that cycle it checks eof_o, win_valid_o, the centre position and all 49 window fields against values derived from the pixel formula. The second case is the strobe of centre (0, 0) of the next frame, which comes after the eof pulse while the line delays still hold the old frame. There the bench expects border_o high and a zero window.

// File: rtl/win7_pkg.sv
package win7_pkg;
  localparam int unsigned DEF_IMG_W = 512;
  localparam int unsigned DEF_IMG_H = 512;
  localparam int unsigned DEF_WIN   = 7;
  localparam int unsigned DEF_DW    = 13;
endpackage

// File: rtl/win7_pos_ctr.sv
module win7_pos_ctr #(
  parameter int unsigned W  = 512,
  parameter int unsigned H  = 512,
  parameter int unsigned CW = 9,
  parameter int unsigned RW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic [CW-1:0] col_o,
  output logic [RW-1:0] row_o,
  output logic          last_o
);
  localparam logic [CW-1:0] COL_MAX = CW'(W - 1);
  localparam logic [RW-1:0] ROW_MAX = RW'(H - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_o <= '0;
      row_o <= '0;
    end else if (en_i) begin
      if (col_o == COL_MAX) begin
        col_o <= '0;
        row_o <= (row_o == ROW_MAX) ? '0 : row_o + 1'b1;
      end else begin
        col_o <= col_o + 1'b1;
      end
    end
  end

  assign last_o = (col_o == COL_MAX) && (row_o == ROW_MAX);
endmodule

// File: rtl/win7_line_buf.sv
module win7_line_buf #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned DW    = 13,
  parameter int unsigned AW    = 9
) (
  input  logic          clk_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o
);
  logic [DW-1:0] mem [DEPTH];

  // read-before-write at the same address gives a DEPTH-sample delay
  assign dout_o = mem[addr_i];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem[addr_i] <= din_i;
  end
endmodule

// File: rtl/win7_gen.sv
module win7_gen #(
  parameter int unsigned IMG_W = win7_pkg::DEF_IMG_W,
  parameter int unsigned IMG_H = win7_pkg::DEF_IMG_H,
  parameter int unsigned WIN   = win7_pkg::DEF_WIN,
  parameter int unsigned DW    = win7_pkg::DEF_DW,
  localparam int unsigned CW   = $clog2(IMG_W),
  localparam int unsigned RW   = $clog2(IMG_H)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pix_valid_i,
  input  logic [DW-1:0]           pix_i,
  output logic [WIN*WIN*DW-1:0]   win_o,
  output logic                    out_stb_o,
  output logic                    win_valid_o,
  output logic                    border_o,
  output logic [RW-1:0]           ctr_row_o,
  output logic [CW-1:0]           ctr_col_o,
  output logic                    eof_o
);
  localparam int unsigned HALF = WIN / 2;
  localparam int unsigned NL   = WIN - 1;
  localparam int unsigned NPIX = WIN * WIN;

  logic [CW-1:0] in_col, c_col;
  logic [RW-1:0] in_row, c_row;
  logic          in_last, c_last;
  logic          primed_q, hit, emit, interior;

  // input raster position, also the line buffer address
  win7_pos_ctr #(.W(IMG_W), .H(IMG_H), .CW(CW), .RW(RW)) u_in_ctr (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(pix_valid_i),
    .col_o (in_col), .row_o(in_row), .last_o(in_last)
  );

  assign hit  = pix_valid_i && (in_row == RW'(HALF)) && (in_col == CW'(HALF));
  assign emit = pix_valid_i && (primed_q || hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  primed_q <= 1'b0;
    else if (hit) primed_q <= 1'b1;
  end

  // centre raster position, lags input by HALF lines and HALF pixels
  win7_pos_ctr #(.W(IMG_W), .H(IMG_H), .CW(CW), .RW(RW)) u_ctr_ctr (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(emit),
    .col_o (c_col), .row_o(c_row), .last_o(c_last)
  );

  assign interior = (c_row >= RW'(HALF)) && (c_row <= RW'(IMG_H - 1 - HALF)) &&
                    (c_col >= CW'(HALF)) && (c_col <= CW'(IMG_W - 1 - HALF));

  // row taps: tap[WIN-1] newest line, tap[0] oldest
  logic [DW-1:0] tap [WIN];
  assign tap[WIN-1] = pix_i;

  for (genvar k = 0; k < NL; k++) begin : g_line
    win7_line_buf #(.DEPTH(IMG_W), .DW(DW), .AW(CW)) u_line (
      .clk_i (clk_i),
      .wr_i  (pix_valid_i),
      .addr_i(in_col),
      .din_i (tap[WIN-1-k]),
      .dout_o(tap[WIN-2-k])
    );
  end

  // horizontal shift chains, sh[r][0] newest
  logic [DW-1:0] sh [WIN][NL];

  for (genvar r = 0; r < WIN; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int j = 0; j < NL; j++) sh[r][j] <= '0;
      end else if (pix_valid_i) begin
        sh[r][0] <= tap[r];
        for (int j = 1; j < NL; j++) sh[r][j] <= sh[r][j-1];
      end
    end
  end

  logic [NPIX*DW-1:0] nxt;
  always_comb begin
    nxt = '0;
    for (int r = 0; r < WIN; r++) begin
      for (int c = 0; c < WIN; c++) begin
        if (c == WIN - 1) nxt[(r*WIN+c)*DW +: DW] = tap[r];
        else              nxt[(r*WIN+c)*DW +: DW] = sh[r][WIN-2-c];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_o       <= '0;
      out_stb_o   <= 1'b0;
      win_valid_o <= 1'b0;
      border_o    <= 1'b0;
      ctr_row_o   <= '0;
      ctr_col_o   <= '0;
      eof_o       <= 1'b0;
    end else begin
      out_stb_o   <= emit;
      win_valid_o <= emit && interior;
      border_o    <= emit && !interior;
      eof_o       <= pix_valid_i && in_last;
      if (emit) begin
        win_o     <= interior ? nxt : '0;
        ctr_row_o <= c_row;
        ctr_col_o <= c_col;
      end
    end
  end

  logic unused_last;
  assign unused_last = c_last;
endmodule

// File: rtl/win7_gen_chk.sv
module win7_gen_chk #(
  parameter int unsigned IMG_W = 512,
  parameter int unsigned IMG_H = 512,
  parameter int unsigned WIN   = 7,
  parameter int unsigned DW    = 13
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  pix_valid_i,
  input logic [WIN*WIN*DW-1:0] win_o,
  input logic                  out_stb_o,
  input logic                  win_valid_o,
  input logic                  border_o,
  input logic                  eof_o
);
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(win_valid_o && border_o)); // R9

  AST_VALID_HAS_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> out_stb_o); // R6

  AST_BORDER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    border_o |-> (out_stb_o && win_o == '0)); // R7

  AST_STALL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> (!out_stb_o && !eof_o)); // R2

  AST_STB_AFTER_PIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_stb_o |-> $past(pix_valid_i)); // R3

  AST_EOF_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> !eof_o); // R8

  if (IMG_W >= WIN && IMG_H >= WIN) begin : g_eof_win
    AST_EOF_LAST_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eof_o |-> win_valid_o); // R8
  end
endmodule

bind win7_gen win7_gen_chk #(.IMG_W(IMG_W), .IMG_H(IMG_H), .WIN(WIN), .DW(DW)) i_win7_gen_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pix_valid_i(pix_valid_i),
  .win_o      (win_o),
  .out_stb_o  (out_stb_o),
  .win_valid_o(win_valid_o),
  .border_o   (border_o),
  .eof_o      (eof_o)
);

// File: tb/test_win7_gen.sv
module test_win7_gen;
  localparam int W    = 10;
  localparam int H    = 8;
  localparam int WIN  = 7;
  localparam int DW   = 13;
  localparam int CW   = $clog2(W);
  localparam int RW   = $clog2(H);
  localparam int NFR  = 4;
  localparam int NTOT = NFR * W * H;
  localparam int LAG  = 3 * W + 3;

  logic                  clk_i = 1'b0;
  logic                  rst_ni = 1'b0;
  logic                  pix_valid_i = 1'b0;
  logic [DW-1:0]         pix_i = '0;
  logic [WIN*WIN*DW-1:0] win_o;
  logic                  out_stb_o, win_valid_o, border_o, eof_o;
  logic [RW-1:0]         ctr_row_o;
  logic [CW-1:0]         ctr_col_o;

  int errors = 0;
  int checks = 0;
  int strobes = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  win7_gen #(.IMG_W(W), .IMG_H(H), .WIN(WIN), .DW(DW)) i_win7_gen (.*);

  function automatic logic [DW-1:0] pval(int lin);
    return DW'((lin * 7 + 3) % (1 << DW));
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // judge outputs produced by the previous accepted/stalled cycle
  task automatic judge(bit pv, int pidx);
    bit exp_stb, exp_eof, inter;
    int cidx, fr, cy, cx, bad, first_act, first_exp;
    exp_stb = pv && (pidx >= LAG);
    exp_eof = pv && ((pidx % (W*H)) == W*H - 1);
    chk(eof_o == exp_eof, "R8", "eof_o", eof_o, exp_eof);
    chk(out_stb_o == exp_stb, pv ? "R3" : "R2", "out_stb_o", out_stb_o, exp_stb);
    if (!exp_stb) begin
      chk(!win_valid_o && !border_o, "R9", "flags without strobe", {win_valid_o, border_o}, 0);
      return;
    end
    strobes++;
    cidx = pidx - LAG;
    fr = cidx / (W*H);
    cy = (cidx % (W*H)) / W;
    cx = cidx % W;
    inter = (cy >= 3) && (cy <= H-4) && (cx >= 3) && (cx <= W-4);
    chk(ctr_row_o == RW'(cy) && ctr_col_o == CW'(cx), "R4", "centre row*100+col",
        ctr_row_o*100 + ctr_col_o, cy*100 + cx);
    chk(win_valid_o == inter, "R6", "win_valid_o", win_valid_o, inter);
    chk(border_o == !inter, "R7", "border_o", border_o, !inter);
    if (exp_eof) chk(inter && cy == H-4 && cx == W-4, "R8", "centre at eof", cy*100+cx, (H-4)*100+W-4);
    bad = 0; first_act = 0; first_exp = 0;
    for (int r = 0; r < WIN; r++) begin
      for (int c = 0; c < WIN; c++) begin
        int e;
        e = inter ? int'(pval(fr*W*H + (cy-3+r)*W + (cx-3+c))) : 0;
        if (int'(win_o[(r*WIN+c)*DW +: DW]) != e) begin
          if (bad == 0) begin first_act = int'(win_o[(r*WIN+c)*DW +: DW]); first_exp = e; end
          bad++;
        end
      end
    end
    chk(bad == 0, inter ? "R5" : "R7", "window field", first_act, first_exp);
  endtask

  initial begin
    int idx, cyc;
    bit pv;
    int pidx;
    repeat (3) @(negedge clk_i);
    chk(!out_stb_o && !win_valid_o && !border_o && !eof_o, "R1", "flags in reset",
        {out_stb_o, win_valid_o, border_o, eof_o}, 0);
    chk(win_o == '0 && ctr_row_o == '0 && ctr_col_o == '0, "R1", "data in reset", 1, 0);
    rst_ni = 1'b1;
    idx = 0; cyc = 0; pv = 1'b0; pidx = 0;
    while (idx < NTOT) begin
      bit gap;
      @(negedge clk_i);
      judge(pv, pidx);
      gap = ((cyc % 7) == 3) || ((cyc % 11) == 0) || (idx >= 2*W*H && idx < 3*W*H && cyc[0]);
      cyc++;
      if (gap) begin
        pix_valid_i = 1'b0;
        pix_i = DW'(8191 - cyc);
        pv = 1'b0;
      end else begin
        pix_valid_i = 1'b1;
        pix_i = pval(idx);
        pv = 1'b1;
        pidx = idx;
        idx++;
      end
    end
    @(negedge clk_i);
    judge(pv, pidx);
    pix_valid_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      judge(1'b0, 0);
    end
    chk(strobes == NTOT - LAG, "R3", "strobe count", strobes, NTOT - LAG);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule